// File: doc/BRIEF.md
# Spread Spectrum Modulation Profile Generator

This block produces the digital frequency-offset profile that a clock divider or a PLL feedback controller follows to spread the energy of a clock over a band of frequencies. Each modulation period is a triangle. The offset starts at the profile minimum, climbs linearly to the maximum during the first half, and falls linearly back during the second half. Every reference clock the block presents one signed offset sample. One LSB of the offset is 1/8 of a part per ten thousand of the target frequency, which is 0.00125 %.

Two spread shapes are available. Center spread places the profile symmetrically around the target, so the average over a period is exactly the target. Down spread puts the profile peak at the target and keeps every other sample below it. A 5-bit magnitude code sets the width of the spread. A select input chooses between a slow modulation rate near 32 kHz and a fast rate near 120 kHz. The period length in reference clocks is derived from a parameterized reference frequency. All settings are captured only when a period begins. A one-cycle strobe marks each return to the profile minimum.

Top module: `ssm_profile_gen`

## Requirements
- R1: While reset is high, and in the cycle that follows a reset edge, offset_o is 0 and strobe_o is 0.
- R2: From the first clock edge that samples en_i low, offset_o is 0 and strobe_o is 0, and both stay there while en_i remains low.
- R3: The first edge that samples en_i high after it was low starts a new period. In the cycle after that edge, strobe_o is 1 and offset_o equals the profile minimum.
- R4: A period lasts 2*H reference clocks. H = REF_HZ/(2*LO_RATE_HZ) when fast_i=0 and H = REF_HZ/(2*HI_RATE_HZ) when fast_i=1. strobe_o is 1 exactly in the first cycle of each period and 0 in every other cycle.
- R5: With span S, in cycle k of a period (k = 0 .. H-1) offset_o = min + floor(S*k/H). In cycle H+j (j = 0 .. H-1) offset_o = max - floor(S*j/H).
- R6: Center spread (down_i=0) with clamped code c gives min = -100*c and max = +100*c, so c counts steps of 0.125 % per side. The offsets of one complete period sum to exactly 0.
- R7: Down spread (down_i=1) with clamped code c gives min = -200*c and max = 0, so c counts steps of 0.25 % total. No sample is positive, and the sum over a complete period is negative.
- R8: The code mag_i is clamped to the legal range 1..16 before use: 0 acts as 1 and any value above 16 acts as 16. In both modes the span is S = 200*c.
- R9: Changes of down_i, fast_i or mag_i during a period do not alter that period. They take effect at the next period start.
- R10: offset_o always stays within the range from the minimum to the maximum of the profile currently latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enables modulation; low forces a zero offset |
| down_i | input | 1 | Spread shape: 0 center, 1 down |
| fast_i | input | 1 | Modulation rate: 0 slow, 1 fast |
| mag_i | input | 5 | Spread magnitude code, clamped to 1..16 |
| offset_o | output | 13 | Signed offset, LSB = 1/8 part per ten thousand |
| strobe_o | output | 1 | One-cycle pulse at each period start |

## Verification
A wrong phase counter or half-length shows up as a strobe that arrives early or late, so the first bad strobe appears within one period. A corrupted ramp accumulator gives a wrong offset on the very next sample, because every cycle is compared against a closed-form expected value. A wrong latched configuration appears at the first sample of the period, where the minimum is wrong. It also breaks the per-period sum: that sum must be exactly zero for center spread and negative for down spread, and it is checked at every period boundary.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    localparam int MAG_W    = 5;
    localparam int MAG_MIN  = 1;
    localparam int MAG_MAX  = 16;
    localparam int STEP_LSB = 100;
    localparam int SPAN_MAX = 2 * STEP_LSB * MAG_MAX;
    localparam int OFF_W    = $clog2(SPAN_MAX + 1) + 1;

    typedef logic [MAG_W-1:0]        mag_t;
    typedef logic [OFF_W-1:0]        span_t;
    typedef logic signed [OFF_W-1:0] off_t;

    typedef struct packed {
        logic down;
        mag_t code;
    } cfg_t;

    function automatic mag_t mag_clamp(input mag_t m);
        if (int'(m) < MAG_MIN) return mag_t'(MAG_MIN);
        if (int'(m) > MAG_MAX) return mag_t'(MAG_MAX);
        return m;
    endfunction

    function automatic span_t span_of(input mag_t c);
        return span_t'(2 * STEP_LSB * int'(c));
    endfunction

    function automatic off_t prof_lo(input cfg_t c);
        int a;
        a = STEP_LSB * int'(c.code);
        return off_t'(c.down ? -(2 * a) : -a);
    endfunction

    function automatic off_t prof_hi(input cfg_t c);
        int a;
        a = STEP_LSB * int'(c.code);
        return off_t'(c.down ? 0 : a);
    endfunction

endpackage

// File: rtl/ssm_timebase.sv
module ssm_timebase #(
    parameter int HALF_LO = 50,
    parameter int HALF_HI = 13,
    parameter int CNT_W   = 6
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             fast_i,
    output logic             start_o,
    output logic             turn_o,
    output logic             adv_o,
    output logic             run_o,
    output logic             fall_o,
    output logic             first_o,
    output logic [CNT_W-1:0] half_o
);

    logic             run_q, fall_q, fast_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    assign half_o  = fast_q ? CNT_W'(HALF_HI) : CNT_W'(HALF_LO);
    assign at_end  = (cnt_q == half_o - CNT_W'(1));
    assign start_o = en_i & (~run_q | (fall_q & at_end));
    assign turn_o  = en_i & run_q & ~fall_q & at_end;
    assign adv_o   = en_i & run_q & ~at_end;
    assign run_o   = run_q;
    assign fall_o  = fall_q;
    assign first_o = run_q & ~fall_q & (cnt_q == '0);

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            run_q  <= 1'b0;
            fall_q <= 1'b0;
            fast_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_o) begin
            run_q  <= 1'b1;
            fall_q <= 1'b0;
            fast_q <= fast_i;
            cnt_q  <= '0;
        end else if (turn_o) begin
            fall_q <= 1'b1;
            cnt_q  <= '0;
        end else if (adv_o) begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/ssm_ramp.sv
module ssm_ramp
    import ssm_pkg::*;
#(
    parameter int HALF_LO = 50,
    parameter int HALF_HI = 13,
    parameter int CNT_W   = 6
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic             turn_i,
    input  logic             adv_i,
    input  logic             fast_i,
    input  span_t            span_i,
    input  logic [CNT_W-1:0] half_i,
    output span_t            lvl_o
);

    span_t            q_q, p_q;
    logic [CNT_W-1:0] r_q, acc_q, acc_nx;
    logic [CNT_W:0]   acc_sum;
    logic             carry;

    assign acc_sum = {1'b0, acc_q} + {1'b0, r_q};
    assign carry   = (acc_sum >= {1'b0, half_i});
    assign acc_nx  = carry ? CNT_W'(acc_sum - {1'b0, half_i}) : CNT_W'(acc_sum);
    assign lvl_o   = p_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q_q   <= '0;
            r_q   <= '0;
            acc_q <= '0;
            p_q   <= '0;
        end else if (start_i) begin
            q_q   <= fast_i ? span_t'(int'(span_i) / HALF_HI) : span_t'(int'(span_i) / HALF_LO);
            r_q   <= fast_i ? CNT_W'(int'(span_i) % HALF_HI) : CNT_W'(int'(span_i) % HALF_LO);
            acc_q <= '0;
            p_q   <= '0;
        end else if (turn_i) begin
            acc_q <= '0;
            p_q   <= '0;
        end else if (adv_i) begin
            acc_q <= acc_nx;
            p_q   <= p_q + q_q + span_t'(carry);
        end
    end

endmodule

// File: rtl/ssm_profile_gen.sv
module ssm_profile_gen
    import ssm_pkg::*;
#(
    parameter int REF_HZ     = 250_000_000,
    parameter int LO_RATE_HZ = 31_250,
    parameter int HI_RATE_HZ = 120_000
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    en_i,
    input  logic                    down_i,
    input  logic                    fast_i,
    input  logic [MAG_W-1:0]        mag_i,
    output logic signed [OFF_W-1:0] offset_o,
    output logic                    strobe_o
);

    localparam int HALF_LO  = REF_HZ / (2 * LO_RATE_HZ);
    localparam int HALF_HI  = REF_HZ / (2 * HI_RATE_HZ);
    localparam int HALF_MAX = (HALF_LO > HALF_HI) ? HALF_LO : HALF_HI;
    localparam int CNT_W    = $clog2(HALF_MAX + 1);

    logic             start_w, turn_w, adv_w, run_w, fall_w, first_w;
    logic [CNT_W-1:0] half_w;
    span_t            lvl_w;
    cfg_t             cfg_q;
    mag_t             mag_c;
    off_t             lo_w, hi_w;

    assign mag_c = mag_clamp(mag_i);

    ssm_timebase #(.HALF_LO(HALF_LO), .HALF_HI(HALF_HI), .CNT_W(CNT_W)) u_tb (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (en_i),
        .fast_i  (fast_i),
        .start_o (start_w),
        .turn_o  (turn_w),
        .adv_o   (adv_w),
        .run_o   (run_w),
        .fall_o  (fall_w),
        .first_o (first_w),
        .half_o  (half_w)
    );

    ssm_ramp #(.HALF_LO(HALF_LO), .HALF_HI(HALF_HI), .CNT_W(CNT_W)) u_ramp (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_w),
        .turn_i  (turn_w),
        .adv_i   (adv_w),
        .fast_i  (fast_i),
        .span_i  (span_of(mag_c)),
        .half_i  (half_w),
        .lvl_o   (lvl_w)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q <= '{down: 1'b0, code: mag_t'(MAG_MIN)};
        end else if (start_w) begin
            cfg_q <= '{down: down_i, code: mag_c};
        end
    end

    assign lo_w = prof_lo(cfg_q);
    assign hi_w = prof_hi(cfg_q);

    always_comb begin
        if (!run_w)      offset_o = '0;
        else if (fall_w) offset_o = hi_w - $signed(lvl_w);
        else             offset_o = lo_w + $signed(lvl_w);
    end

    assign strobe_o = first_w;

endmodule

// File: rtl/ssm_profile_chk.sv
module ssm_profile_chk
    import ssm_pkg::*;
(
    input logic                    clk_i,
    input logic                    rst_i,
    input logic                    en_i,
    input logic                    run,
    input logic                    down,
    input logic [MAG_W-1:0]        code,
    input logic signed [OFF_W-1:0] offset_o,
    input logic                    strobe_o
);

    logic signed [OFF_W:0] amp;
    logic signed [OFF_W:0] off_x;
    assign amp   = (OFF_W+1)'(STEP_LSB * int'(code));
    assign off_x = {offset_o[OFF_W-1], offset_o};

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i)
        rst_i |=> (offset_o == '0 && !strobe_o));

    // R2
    disabled_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (offset_o == '0 && !strobe_o));

    // R3
    enable_starts_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(en_i) |=> strobe_o);

    // R4
    strobe_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_o |=> !strobe_o);

    // R7
    down_not_above_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (run && down) |-> (offset_o <= 0));

    // R10
    center_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (run && !down) |-> (off_x <= amp && off_x >= -amp));

    // R10
    down_floor_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (run && down) |-> (off_x >= -(amp + amp)));

endmodule

bind ssm_profile_gen ssm_profile_chk u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (en_i),
    .run      (run_w),
    .down     (cfg_q.down),
    .code     (cfg_q.code),
    .offset_o (offset_o),
    .strobe_o (strobe_o)
);

// File: tb/ssm_profile_gen_tb.sv
module ssm_profile_gen_tb;

    localparam int REF_HZ = 3_200_000;
    localparam int LO_HZ  = 32_000;
    localparam int HI_HZ  = 120_000;
    localparam int HL     = REF_HZ / (2 * LO_HZ);
    localparam int HH     = REF_HZ / (2 * HI_HZ);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en = 1'b0;
    logic              down = 1'b0;
    logic              fast = 1'b0;
    logic [4:0]        mag = 5'd1;
    logic signed [12:0] offset;
    logic              strobe;

    always #2 clk = ~clk;

    ssm_profile_gen #(.REF_HZ(REF_HZ), .LO_RATE_HZ(LO_HZ), .HI_RATE_HZ(HI_HZ)) u_dut (
        .clk_i    (clk),
        .rst_i    (rst),
        .en_i     (en),
        .down_i   (down),
        .fast_i   (fast),
        .mag_i    (mag),
        .offset_o (offset),
        .strobe_o (strobe)
    );

    typedef struct {
        int    off;
        bit    stb;
        bit    run;
        bit    dn;
        int    due;
        string tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    bit    done   = 0;

    int m_run = 0, m_k = 0, m_down = 0, m_fast = 0, m_code = 1;

    always @(posedge clk) cyc = cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int clampc(input int c);
        if (c < 1) return 1;
        if (c > 16) return 16;
        return c;
    endfunction

    function automatic int exp_off(input int d, input int f, input int c, input int k);
        int h, s, lo, hi;
        h  = f ? HH : HL;
        s  = 200 * c;
        lo = d ? -s : -(s / 2);
        hi = d ? 0 : s / 2;
        if (k < h) return lo + (s * k) / h;
        return hi - (s * (k - h)) / h;
    endfunction

    // driver: applies inputs, predicts the state after the coming edge
    task automatic step(input bit e, input bit d, input bit f, input int c, input string tg);
        item_t it;
        string t;
        t = tg;
        en = e; down = d; fast = f; mag = 5'(c);
        if (!e) begin
            m_run = 0; m_k = 0;
        end else if (m_run == 0 || m_k == 2 * (m_fast ? HH : HL) - 1) begin
            if (m_run == 0) t = "R3";
            m_run = 1; m_k = 0; m_down = d; m_fast = f; m_code = clampc(c);
        end else begin
            m_k++;
        end
        it.run = (m_run != 0);
        it.off = it.run ? exp_off(m_down, m_fast, m_code, m_k) : 0;
        it.stb = it.run && (m_k == 0);
        it.dn  = (m_down != 0);
        it.due = cyc + 1;
        it.tag = t;
        q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic steps(input int n, input bit e, input bit d, input bit f, input int c, input string tg);
        for (int i = 0; i < n; i++) step(e, d, f, c, tg);
    endtask

    // monitor: pops due items and compares, also checks per-period sums
    int  psum = 0;
    bit  pvalid = 0;
    bit  pdown = 0;
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            check(int'(offset) == it.off, it.tag, int'(offset), it.off);
            check(strobe == it.stb, "R4", int'(strobe), int'(it.stb));
            if (!it.run) begin
                pvalid = 0;
            end else if (it.stb) begin
                if (pvalid && !pdown) check(psum == 0, "R6", psum, 0);
                if (pvalid && pdown)  check(psum < 0, "R7", psum, -1);
                pvalid = 1; pdown = it.dn; psum = int'(offset);
            end else begin
                psum += int'(offset);
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 20000);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        rst = 1'b1; en = 1'b1; down = 1'b0; fast = 1'b1; mag = 5'd4;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(offset == 0, "R1", int'(offset), 0);
        check(strobe == 1'b0, "R1", int'(strobe), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        // center, fast, code 4: two full periods plus part of a third
        steps(2 * 2 * HH + HH, 1, 0, 1, 4, "R6");
        // inputs change mid-period; current period must not change
        steps(HH, 1, 1, 0, 20, "R9");
        // down, slow, code 20 clamps to 16
        steps(2 * 2 * HL, 1, 1, 0, 20, "R8");
        steps(30, 1, 1, 0, 9, "R7");
        // disable mid-period
        steps(6, 0, 0, 1, 9, "R2");
        // restart: down, fast, code 0 clamps to 1
        steps(2 * 2 * HH, 1, 1, 1, 0, "R8");
        // full ramp shape: center, slow, largest code
        steps(2 * HL, 1, 0, 0, 16, "R5");
        steps(2 * 2 * HL, 1, 0, 0, 31, "R10");
        steps(4, 0, 0, 0, 1, "R2");
        @(negedge clk); @(negedge clk);
        finish_run();
    end

endmodule